// File: doc/BRIEF.md
# Halfword Zero-Extend-and-Add Execution Unit

This unit executes one instruction: it takes a byte-aligned 16-bit slice of a second operand, widens it with zeros and adds it to a first operand. It accepts a 32-bit instruction word in one of two fixed bit layouts, chosen by a select input. The first is a conditional layout with a 4-bit predicate field. The second is a wide unconditional layout. The unit decodes the register indices and a 2-bit rotate field from the word. It checks the predicate against the current N/Z/C/V flags and issues a register write-back with the sum.

Operand values arrive in the same cycle as the instruction word; the register file that supplies them sits outside the unit. From word and operands to result the path is combinational. The read indices, write index, write enable, result and an "other" flag are registered on one clock edge. The unit never produces or changes flags. Words that are not this operation raise "other" and suppress the write.

Top module: `hxa_unit`

## Requirements
- R1: With `fmt_sel_i`=1 (wide layout) the word decodes only when `(instr & 0xFFF0F0C0) == 0xFA10F080`. In that layout the first-operand index is [19:16], the destination [11:8], the rotate field [5:4] and the second-operand index [3:0].
- R2: With `fmt_sel_i`=0 (conditional layout) the word decodes only when `(instr & 0x0FF003F0) == 0x06F00070`. In that layout the predicate is [31:28], the first-operand index [19:16], the destination [15:12], the rotate field [11:10] and the second-operand index [3:0].
- R3: A word whose fixed bits do not match the selected layout gives `other_o`=1 and `wr_en_o`=0.
- R4: In the conditional layout, a predicate field of 1111 or a first-operand index of 1111 gives `other_o`=1 and `wr_en_o`=0, even when the fixed bits match.
- R5: The result is `opa_i` plus the low 16 bits of `opb_i`, zero-extended, after `opb_i` is rotated right by 8 times the rotate field (0, 8, 16 or 24 bits).
- R6: The add wraps modulo 2^32; no carry is produced. For example 0xFFFFFFFF + 0x0001 gives 0x00000000.
- R7: In the conditional layout the write happens only when the predicate passes. `flags_i` is {N,Z,C,V} in bits [3:0]. The predicate codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. A failed predicate gives `wr_en_o`=0 and `other_o`=0.
- R8: A decoded wide-layout word always writes, whatever the flags are.
- R9: All outputs show the word that was presented one rising edge earlier. The index outputs follow the selected layout's field positions whether or not the word decodes. A synchronous active-high reset clears `wr_en_o`, `other_o`, the indices and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| fmt_sel_i | input | 1 | 0 = conditional layout, 1 = wide layout |
| opa_i | input | 32 | First operand value (accumulator) |
| opb_i | input | 32 | Second operand value (rotated source) |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| rn_idx_o | output | 4 | First-operand read index |
| rm_idx_o | output | 4 | Second-operand read index |
| rd_idx_o | output | 4 | Destination write index |
| wr_en_o | output | 1 | Register write enable |
| result_o | output | 32 | Sum to write back |
| other_o | output | 1 | Word is not this operation |

## Verification
Some properties are checked on every cycle by the assertions. A raised "other" never comes with a write. A decoded wide-layout word always writes. The always-pass predicate always writes. Any written result exceeds the previous cycle's first operand, modulo 2^32, by less than 2^16. The sum with a zero rotate is also checked exactly. Other behaviours only show up in the bench's scenarios: the exact field positions of both layouts, every entry of the predicate table, the rejection of predicate 1111 and first-operand index 1111, and the rotations by 8, 16 and 24 with wrap-around.

// File: rtl/hxa_pkg.sv
package hxa_pkg;
  localparam int INSTR_W = 32;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int ROT_W   = 2;
  localparam int EXT_W   = 16;
  localparam int FLG_W   = 4;

  // conditional layout
  localparam logic [INSTR_W-1:0] CND_MASK  = 32'h0FF0_03F0;
  localparam logic [INSTR_W-1:0] CND_VALUE = 32'h06F0_0070;
  // wide layout
  localparam logic [INSTR_W-1:0] WID_MASK  = 32'hFFF0_F0C0;
  localparam logic [INSTR_W-1:0] WID_VALUE = 32'hFA10_F080;

  localparam logic [IDX_W-1:0] IDX_RESERVED  = '1;
  localparam logic [FLG_W-1:0] PRED_RESERVED = 4'hF;

  typedef enum logic [FLG_W-1:0] {
    P_ZSET = 4'd0, P_ZCLR = 4'd1, P_CSET = 4'd2, P_CCLR = 4'd3,
    P_NSET = 4'd4, P_NCLR = 4'd5, P_VSET = 4'd6, P_VCLR = 4'd7,
    P_UGT  = 4'd8, P_ULE  = 4'd9, P_SGE  = 4'd10, P_SLT = 4'd11,
    P_SGT  = 4'd12, P_SLE = 4'd13, P_ANY  = 4'd14, P_RSV = 4'd15
  } pred_e;

  typedef struct packed {
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rm;
    logic [ROT_W-1:0] rot;
    logic [FLG_W-1:0] pred;
    logic             hit;
    logic             conditional;
  } dec_t;
endpackage

// File: rtl/hxa_decode.sv
module hxa_decode
  import hxa_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               fmt_wide,
  output dec_t               dec
);
  logic cnd_fixed, wid_fixed;

  assign cnd_fixed = (instr & CND_MASK) == CND_VALUE;
  assign wid_fixed = (instr & WID_MASK) == WID_VALUE;

  always_comb begin
    dec = '0;
    if (fmt_wide) begin
      dec.rn          = instr[19:16];
      dec.rd          = instr[11:8];
      dec.rm          = instr[3:0];
      dec.rot         = instr[5:4];
      dec.pred        = P_ANY;
      dec.conditional = 1'b0;
      dec.hit         = wid_fixed;
    end else begin
      dec.rn          = instr[19:16];
      dec.rd          = instr[15:12];
      dec.rm          = instr[3:0];
      dec.rot         = instr[11:10];
      dec.pred        = instr[31:28];
      dec.conditional = 1'b1;
      // reserved predicate or reserved first index: a different operation
      dec.hit         = cnd_fixed && (instr[31:28] != PRED_RESERVED)
                        && (instr[19:16] != IDX_RESERVED);
    end
  end
endmodule

// File: rtl/hxa_predicate.sv
module hxa_predicate
  import hxa_pkg::*;
(
  input  logic [FLG_W-1:0] pred,
  input  logic [FLG_W-1:0] flags,
  output logic             pass
);
  logic fn, fz, fc, fv, sge;

  assign {fn, fz, fc, fv} = flags;
  assign sge = (fn == fv);

  always_comb begin
    unique case (pred_e'(pred))
      P_ZSET: pass = fz;
      P_ZCLR: pass = !fz;
      P_CSET: pass = fc;
      P_CCLR: pass = !fc;
      P_NSET: pass = fn;
      P_NCLR: pass = !fn;
      P_VSET: pass = fv;
      P_VCLR: pass = !fv;
      P_UGT:  pass = fc && !fz;
      P_ULE:  pass = !fc || fz;
      P_SGE:  pass = sge;
      P_SLT:  pass = !sge;
      P_SGT:  pass = !fz && sge;
      P_SLE:  pass = fz || !sge;
      P_ANY:  pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/hxa_datapath.sv
module hxa_datapath
  import hxa_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int RW    = ROT_W,
  parameter int EW    = EXT_W,
  parameter int STEP  = 8
) (
  input  logic [W-1:0]  acc,
  input  logic [W-1:0]  src,
  input  logic [RW-1:0] rot,
  output logic [W-1:0]  sum
);
  localparam int NROT = 1 << RW;

  logic [W-1:0] cand [NROT];
  logic [W-1:0] rotated;
  logic [W-1:0] widened;

  // one candidate per byte-multiple rotation
  for (genvar k = 0; k < NROT; k++) begin : g_rot
    if (k == 0) begin : g_zero
      assign cand[k] = src;
    end else begin : g_turn
      assign cand[k] = {src[STEP*k-1:0], src[W-1:STEP*k]};
    end
  end

  assign rotated = cand[rot];
  assign widened = {{(W-EW){1'b0}}, rotated[EW-1:0]};
  assign sum     = acc + widened;   // wraps modulo 2^W
endmodule

// File: rtl/hxa_unit.sv
module hxa_unit
  import hxa_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               fmt_sel_i,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [FLG_W-1:0]   flags_i,
  output logic [IDX_W-1:0]   rn_idx_o,
  output logic [IDX_W-1:0]   rm_idx_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic               wr_en_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               other_o
);
  dec_t              dec;
  logic              pass;
  logic [DATA_W-1:0] sum;

  hxa_decode u_dec (
    .instr    (instr_i),
    .fmt_wide (fmt_sel_i),
    .dec      (dec)
  );

  hxa_predicate u_pred (
    .pred  (dec.pred),
    .flags (flags_i),
    .pass  (pass)
  );

  hxa_datapath #(
    .W (DATA_W), .RW (ROT_W), .EW (EXT_W), .STEP (8)
  ) u_dp (
    .acc (opa_i),
    .src (opb_i),
    .rot (dec.rot),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rn_idx_o <= '0;
      rm_idx_o <= '0;
      rd_idx_o <= '0;
      wr_en_o  <= 1'b0;
      other_o  <= 1'b0;
      result_o <= '0;
    end else begin
      rn_idx_o <= dec.rn;
      rm_idx_o <= dec.rm;
      rd_idx_o <= dec.rd;
      wr_en_o  <= dec.hit && (pass || !dec.conditional);
      other_o  <= !dec.hit;
      result_o <= sum;
    end
  end

  // R3, R4: a rejected word never writes
  a_r3_other_blocks_write: assert property (@(posedge clk) disable iff (rst)
    other_o |-> !wr_en_o);

  // R8: decoded wide word writes regardless of flags
  a_r8_wide_always_writes: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fmt_sel_i) && !other_o) |-> wr_en_o);

  // R7: always-pass predicate writes when decoded
  a_r7_any_pred_writes: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(fmt_sel_i) && ($past(instr_i[31:28]) == 4'hE)
     && !other_o) |-> wr_en_o);

  // R5, R6: written sum exceeds the accumulator by less than 2^16 (mod 2^32)
  a_r5_sum_within_halfword: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && wr_en_o) |->
      ((result_o - $past(opa_i)) >> EXT_W) == '0);

  // R5: zero rotate adds the plain low halfword
  a_r5_zero_rotate_exact: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(fmt_sel_i) && ($past(instr_i[11:10]) == 2'd0)
     && wr_en_o) |->
      result_o == $past(opa_i) + {16'h0, $past(opb_i[15:0])});
endmodule

// File: tb/hxa_unit_bench.sv
module hxa_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic        fmt;
  logic [31:0] opa, opb;
  logic [3:0]  flags;
  logic [3:0]  rn_idx, rm_idx, rd_idx;
  logic        wr_en, other;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  hxa_unit u_hxa_unit (
    .clk (clk), .rst (rst), .instr_i (instr), .fmt_sel_i (fmt),
    .opa_i (opa), .opb_i (opb), .flags_i (flags),
    .rn_idx_o (rn_idx), .rm_idx_o (rm_idx), .rd_idx_o (rd_idx),
    .wr_en_o (wr_en), .result_o (result), .other_o (other)
  );

  function automatic bit pred_ok(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return cy && !z;   4'd9: return !cy || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [31:0] w, input logic f);
    if (f) return (w & 32'hFFF0F0C0) == 32'hFA10F080;
    return ((w & 32'h0FF003F0) == 32'h06F00070) && (w[31:28] != 4'hF)
           && (w[19:16] != 4'hF);
  endfunction

  function automatic logic [31:0] exp_sum(input logic [31:0] a,
      input logic [31:0] b, input logic [1:0] r);
    logic [31:0] t;
    int sh;
    sh = 8 * int'(r);
    t = (sh == 0) ? b : ((b >> sh) | (b << (32 - sh)));
    return a + {16'h0, t[15:0]};
  endfunction

  function automatic logic [31:0] mk_cnd(input logic [3:0] c, input logic [3:0] n,
      input logic [3:0] d, input logic [1:0] r, input logic [3:0] m);
    return 32'h06F00070 | {c, 8'h0, n, d, r, 6'h0, m};
  endfunction

  function automatic logic [31:0] mk_wid(input logic [3:0] n, input logic [3:0] d,
      input logic [1:0] r, input logic [3:0] m);
    return 32'hFA10F080 | {12'h0, n, 4'h0, d, 2'b0, r, m};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic f, input logic [31:0] a,
                     input logic [31:0] b, input logic [3:0] fl, input string req);
    bit h, we;
    logic [3:0] en, ed;
    logic [1:0] er;
    @(negedge clk);
    instr = w; fmt = f; opa = a; opb = b; flags = fl;
    h  = exp_hit(w, f);
    we = h && (f || pred_ok(w[31:28], fl));
    en = w[19:16];
    ed = f ? w[11:8] : w[15:12];
    er = f ? w[5:4] : w[11:10];
    @(posedge clk);
    @(negedge clk);
    chk(req, "other", {31'h0, other}, {31'h0, !h});
    chk(req, "wr_en", {31'h0, wr_en}, {31'h0, we});
    chk("R9", "rn_idx", {28'h0, rn_idx}, {28'h0, en});
    chk("R9", "rd_idx", {28'h0, rd_idx}, {28'h0, ed});
    chk("R9", "rm_idx", {28'h0, rm_idx}, {28'h0, w[3:0]});
    if (we) chk(req, "result", result, exp_sum(a, b, er));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; instr = '0; fmt = 1'b0; opa = '0; opb = '0; flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", "reset wr_en", {31'h0, wr_en}, 32'h0);
    chk("R9", "reset other", {31'h0, other}, 32'h0);
    chk("R9", "reset result", result, 32'h0);
    rst = 1'b0;

    // R5 all rotations, both layouts
    for (int r = 0; r < 4; r++) begin
      run(mk_cnd(4'hE, 4'd1, 4'd2, r[1:0], 4'd3), 1'b0, 32'h1000_0000,
          32'hA1B2_C3D4, 4'h0, "R5");
      run(mk_wid(4'd4, 4'd5, r[1:0], 4'd6), 1'b1, 32'h0000_0100,
          32'h1122_3344, 4'h0, "R5");
    end
    // R6 wrap
    run(mk_cnd(4'hE, 4'd1, 4'd0, 2'd0, 4'd2), 1'b0, 32'hFFFF_FFFF,
        32'h0000_0001, 4'h0, "R6");
    run(mk_wid(4'd1, 4'd0, 2'd2, 4'd2), 1'b1, 32'hFFFF_FFF0,
        32'h00FF_0000, 4'hF, "R6");
    // R7 every predicate with every flag set
    for (int c = 0; c < 15; c++)
      for (int fl = 0; fl < 16; fl++)
        run(mk_cnd(c[3:0], 4'd7, 4'd8, 2'd1, 4'd9), 1'b0, 32'h1234_5678,
            32'h9ABC_DEF0, fl[3:0], "R7");
    // R4 reserved predicate and reserved first index
    run(mk_cnd(4'hF, 4'd1, 4'd2, 2'd0, 4'd3), 1'b0, 32'h1, 32'h2, 4'h0, "R4");
    run(mk_cnd(4'hE, 4'hF, 4'd2, 2'd0, 4'd3), 1'b0, 32'h1, 32'h2, 4'h0, "R4");
    // R8 wide with reserved-looking fields and all flags
    for (int fl = 0; fl < 16; fl++)
      run(mk_wid(4'hF, 4'hF, 2'd3, 4'hF), 1'b1, 32'h0, 32'hFFFF_FFFF,
          fl[3:0], "R8");
    // R3 wrong layout and single-bit corruption of fixed bits
    run(mk_wid(4'd1, 4'd2, 2'd0, 4'd3), 1'b0, 32'h5, 32'h6, 4'h0, "R3");
    run(mk_cnd(4'hE, 4'd1, 4'd2, 2'd0, 4'd3), 1'b1, 32'h5, 32'h6, 4'h0, "R3");
    for (int b = 0; b < 32; b++) begin
      if (32'h0FF003F0 & (32'h1 << b))
        run(mk_cnd(4'hE, 4'd1, 4'd2, 2'd0, 4'd3) ^ (32'h1 << b), 1'b0,
            32'h5, 32'h6, 4'h0, "R2");
      if (32'hFFF0F0C0 & (32'h1 << b))
        run(mk_wid(4'd1, 4'd2, 2'd0, 4'd3) ^ (32'h1 << b), 1'b1,
            32'h5, 32'h6, 4'h0, "R1");
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic f;
      int sel;
      f = 1'($urandom);
      sel = int'($urandom % 4);
      if (sel == 0) w = $urandom;
      else if (f) w = mk_wid(4'($urandom), 4'($urandom), 2'($urandom), 4'($urandom));
      else w = mk_cnd(4'($urandom), 4'($urandom), 4'($urandom), 2'($urandom),
                      4'($urandom));
      run(w, f, $urandom, $urandom, 4'($urandom), f ? "R1" : "R2");
    end
    // R9 reset clears after activity
    @(negedge clk);
    instr = mk_wid(4'd1, 4'd2, 2'd0, 4'd3); fmt = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "reset wr_en again", {31'h0, wr_en}, 32'h0);
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule